// File: doc/BRIEF.md
# YCbCr to RGB Matrix Datapath

This block turns a stream of YCbCr pixels into RGB pixels, one pixel per handshake. Each output channel is the luma sample scaled to the coefficient's fixed-point format, plus up to two chroma products with signed programmable coefficients, plus a signed per-channel offset. The sum is shifted back to the output width and then bounded by a programmable upper and lower limit. The offset also carries the chroma bias removal and the rounding constant. The datapath therefore truncates and has no rounding stage of its own.

Both sides of the block use valid/ready. A pixel moves when valid and ready are both high at a rising clock edge. The producer keeps a pixel on the input until it is taken. The output pixel and its valid stay frozen while the consumer holds ready low. When the output register holds a pixel that the consumer has not taken, the whole pipeline stalls and input ready drops. Configuration arrives as a static bundle and takes effect only through a commit request. The block delays the commit until no pixel is in flight, so a pixel is never computed with a mix of old and new settings. The requester must keep the bundle steady until input ready returns.

Top module: `ycc_rgb_conv`

## Requirements
- R1: During reset and after it, m_valid is low and s_ready is high while en is high. The active set after reset has all coefficients and offsets at zero, the upper limit at all ones and the lower limit at zero, so every channel outputs the Y code unchanged.
- R2: Red = floor((Y·2^14 + A·Cr + OFF_R) / 2^14), then bounded. A is a 17-bit two's-complement coefficient with unity at 2^14. Chroma codes are unsigned. OFF_R is a 32-bit two's-complement value.
- R3: Green uses coefficient B on Cr and C on Cb, plus OFF_G. Blue uses only coefficient D on Cb, plus OFF_B. Luma enters every channel with unit gain.
- R4: The offset is added before the right shift and no further rounding takes place. For example, an offset of -1 yields Y-1, and an offset of 2^13-1 yields Y.
- R5: Each channel is first limited to at most cfg_max and then raised to at least cfg_min. Negative sums give cfg_min, and when cfg_min exceeds cfg_max the output is cfg_min.
- R6: With m_ready held high, a pixel taken at a rising edge appears on the output after the second following rising edge, which is three register stages.
- R7: While m_valid is high and m_ready is low, m_valid stays high, the RGB values stay unchanged and s_ready is low. Pixels are never lost, duplicated or reordered.
- R8: While en is low, m_valid is low, s_ready is high, input pixels are discarded, and pixels already in flight are dropped.
- R9: After a cfg_commit pulse, s_ready is low until the pipeline has emptied and the new set is loaded. Pixels taken up to and including the commit cycle use the old set, and later pixels use the new set.
- R10: Changes on the configuration inputs without a commit have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Conversion enable |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high |
| s_y | input | DW | Luma code |
| s_cb | input | DW | Blue-difference chroma code |
| s_cr | input | DW | Red-difference chroma code |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Consumer ready |
| m_r | output | DW | Red result |
| m_g | output | DW | Green result |
| m_b | output | DW | Blue result |
| cfg_commit | input | 1 | One-cycle request to load the bundle below |
| cfg_coef_a | input | CW | Cr gain for red (signed) |
| cfg_coef_b | input | CW | Cr gain for green (signed) |
| cfg_coef_c | input | CW | Cb gain for green (signed) |
| cfg_coef_d | input | CW | Cb gain for blue (signed) |
| cfg_off_r | input | OFW | Red offset (signed) |
| cfg_off_g | input | OFW | Green offset (signed) |
| cfg_off_b | input | OFW | Blue offset (signed) |
| cfg_max | input | DW | Upper output limit |
| cfg_min | input | DW | Lower output limit |

## Verification
A configuration commit and an output stall can fall in the same cycle. The pending commit must then wait behind a pixel that the consumer refuses to take. The bench provokes this by filling the pipeline with m_ready low and pulsing cfg_commit while the last pixel is held. It then checks that s_ready stays low through the stall and rises only after the drain. The scoreboard judges the result: the held pixels must carry the old coefficients and the first pixel after the drain the new ones. Random commits are also scattered through a run with random valid and ready patterns.

// File: rtl/ycc_pkg.sv
`timescale 1ns/1ps
package ycc_pkg;
  // output channel order used for generate selection
  typedef enum int {CH_R = 0, CH_G = 1, CH_B = 2} chan_e;
  localparam int NCH = 3;
endpackage

// File: rtl/ycc_cfg_bank.sv
`timescale 1ns/1ps
// Active (committed) copy of the conversion settings.
module ycc_cfg_bank #(
  parameter int DW  = 8,
  parameter int CW  = 17,
  parameter int OFW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic signed [CW-1:0]  in_a,
  input  logic signed [CW-1:0]  in_b,
  input  logic signed [CW-1:0]  in_c,
  input  logic signed [CW-1:0]  in_d,
  input  logic signed [OFW-1:0] in_or,
  input  logic signed [OFW-1:0] in_og,
  input  logic signed [OFW-1:0] in_ob,
  input  logic [DW-1:0]         in_hi,
  input  logic [DW-1:0]         in_lo,
  output logic signed [CW-1:0]  act_a,
  output logic signed [CW-1:0]  act_b,
  output logic signed [CW-1:0]  act_c,
  output logic signed [CW-1:0]  act_d,
  output logic signed [OFW-1:0] act_or,
  output logic signed [OFW-1:0] act_og,
  output logic signed [OFW-1:0] act_ob,
  output logic [DW-1:0]         act_hi,
  output logic [DW-1:0]         act_lo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a  <= '0;
      act_b  <= '0;
      act_c  <= '0;
      act_d  <= '0;
      act_or <= '0;
      act_og <= '0;
      act_ob <= '0;
      act_hi <= '1;
      act_lo <= '0;
    end else if (load) begin
      act_a  <= in_a;
      act_b  <= in_b;
      act_c  <= in_c;
      act_d  <= in_d;
      act_or <= in_or;
      act_og <= in_og;
      act_ob <= in_ob;
      act_hi <= in_hi;
      act_lo <= in_lo;
    end
  end
endmodule

// File: rtl/ycc_flow_ctl.sv
`timescale 1ns/1ps
// Stage valid bits, global stall, enable flush and commit gating.
module ycc_flow_ctl #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s_valid,
  input  logic m_ready,
  input  logic cfg_commit,
  output logic s_ready,
  output logic m_valid,
  output logic adv,
  output logic load_cfg
);
  logic [STAGES-1:0] vld;
  logic              pend;
  logic              take;
  logic              empty;

  assign adv      = !vld[STAGES-1] || m_ready;
  assign take     = en && s_valid && adv && !pend;
  assign s_ready  = !en || (adv && !pend);
  assign m_valid  = en && vld[STAGES-1];
  assign empty    = (vld == '0);
  assign load_cfg = pend && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (!en) begin
      vld <= '0;
    end else if (adv) begin
      vld <= {vld[STAGES-2:0], take};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          pend <= 1'b0;
    else if (cfg_commit) pend <= 1'b1;
    else if (load_cfg)   pend <= 1'b0;
  end
endmodule

// File: rtl/ycc_chan.sv
`timescale 1ns/1ps
// One output channel: products, offset sum, shift and saturation.
module ycc_chan #(
  parameter int DW    = 8,
  parameter int CW    = 17,
  parameter int OFW   = 32,
  parameter int CFRAC = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [DW-1:0]         y,
  input  logic [DW-1:0]         cr,
  input  logic [DW-1:0]         cb,
  input  logic signed [CW-1:0]  k_cr,
  input  logic signed [CW-1:0]  k_cb,
  input  logic signed [OFW-1:0] off,
  input  logic [DW-1:0]         lim_hi,
  input  logic [DW-1:0]         lim_lo,
  output logic [DW-1:0]         pix
);
  localparam int PW    = CW + DW + 1;
  localparam int BASEW = (OFW > PW) ? OFW : PW;
  localparam int SW    = ((BASEW > DW + CFRAC + 1) ? BASEW : DW + CFRAC + 1) + 3;

  logic [DW-1:0]        y1;
  logic signed [PW-1:0] p_cr1, p_cb1;
  logic signed [SW-1:0] acc2;
  logic signed [PW-1:0] p_cr_d, p_cb_d;
  logic signed [SW-1:0] y_w, pcr_w, pcb_w, off_w, sum_d;
  logic signed [SW-1:0] q, hi_w, lo_w;
  logic [DW-1:0]        sat_d;

  // stage 1 operands
  assign p_cr_d = PW'(k_cr) * PW'($signed({1'b0, cr}));
  assign p_cb_d = PW'(k_cb) * PW'($signed({1'b0, cb}));

  // stage 2 operands
  assign y_w   = SW'({y1, CFRAC'(0)});
  assign pcr_w = SW'(p_cr1);
  assign pcb_w = SW'(p_cb1);
  assign off_w = SW'(off);
  assign sum_d = y_w + pcr_w + pcb_w + off_w;

  // stage 3: back to output scale, clip then clamp
  assign q    = acc2 >>> CFRAC;
  assign hi_w = SW'({1'b0, lim_hi});
  assign lo_w = SW'({1'b0, lim_lo});

  always_comb begin
    if (q > hi_w)      sat_d = (lim_hi < lim_lo) ? lim_lo : lim_hi;
    else if (q < lo_w) sat_d = lim_lo;
    else               sat_d = q[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y1    <= '0;
      p_cr1 <= '0;
      p_cb1 <= '0;
      acc2  <= '0;
      pix   <= '0;
    end else if (adv) begin
      y1    <= y;
      p_cr1 <= p_cr_d;
      p_cb1 <= p_cb_d;
      acc2  <= sum_d;
      pix   <= sat_d;
    end
  end
endmodule

// File: rtl/ycc_rgb_conv.sv
`timescale 1ns/1ps
// YCbCr to RGB matrix datapath, three register stages, valid/ready.
module ycc_rgb_conv
  import ycc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CW     = 17,
  parameter int OFW    = 32,
  parameter int CRANGE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [DW-1:0]         s_y,
  input  logic [DW-1:0]         s_cb,
  input  logic [DW-1:0]         s_cr,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [DW-1:0]         m_r,
  output logic [DW-1:0]         m_g,
  output logic [DW-1:0]         m_b,
  input  logic                  cfg_commit,
  input  logic signed [CW-1:0]  cfg_coef_a,
  input  logic signed [CW-1:0]  cfg_coef_b,
  input  logic signed [CW-1:0]  cfg_coef_c,
  input  logic signed [CW-1:0]  cfg_coef_d,
  input  logic signed [OFW-1:0] cfg_off_r,
  input  logic signed [OFW-1:0] cfg_off_g,
  input  logic signed [OFW-1:0] cfg_off_b,
  input  logic [DW-1:0]         cfg_max,
  input  logic [DW-1:0]         cfg_min
);
  localparam int CFRAC  = CW - CRANGE - 1;
  localparam int STAGES = 3;

  logic adv, load_cfg;
  logic signed [CW-1:0]  act_a, act_b, act_c, act_d;
  logic signed [OFW-1:0] act_or, act_og, act_ob;
  logic [DW-1:0]         act_max, act_min;
  logic [DW-1:0]         pix_o [NCH];

  ycc_flow_ctl #(.STAGES(STAGES)) u_flow (
    .clk(clk), .rst_n(rst_n), .en(en), .s_valid(s_valid), .m_ready(m_ready),
    .cfg_commit(cfg_commit), .s_ready(s_ready), .m_valid(m_valid),
    .adv(adv), .load_cfg(load_cfg)
  );

  ycc_cfg_bank #(.DW(DW), .CW(CW), .OFW(OFW)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(load_cfg),
    .in_a(cfg_coef_a), .in_b(cfg_coef_b), .in_c(cfg_coef_c), .in_d(cfg_coef_d),
    .in_or(cfg_off_r), .in_og(cfg_off_g), .in_ob(cfg_off_b),
    .in_hi(cfg_max), .in_lo(cfg_min),
    .act_a(act_a), .act_b(act_b), .act_c(act_c), .act_d(act_d),
    .act_or(act_or), .act_og(act_og), .act_ob(act_ob),
    .act_hi(act_max), .act_lo(act_min)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [CW-1:0]  kcr, kcb;
    logic signed [OFW-1:0] koff;
    if (c == int'(CH_R)) begin : g_r
      assign kcr  = act_a;
      assign kcb  = '0;
      assign koff = act_or;
    end else if (c == int'(CH_G)) begin : g_g
      assign kcr  = act_b;
      assign kcb  = act_c;
      assign koff = act_og;
    end else begin : g_b
      assign kcr  = '0;
      assign kcb  = act_d;
      assign koff = act_ob;
    end
    ycc_chan #(.DW(DW), .CW(CW), .OFW(OFW), .CFRAC(CFRAC)) u_ch (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .y(s_y), .cr(s_cr), .cb(s_cb),
      .k_cr(kcr), .k_cb(kcb), .off(koff),
      .lim_hi(act_max), .lim_lo(act_min),
      .pix(pix_o[c])
    );
  end

  assign m_r = pix_o[CH_R];
  assign m_g = pix_o[CH_G];
  assign m_b = pix_o[CH_B];
endmodule

// File: rtl/ycc_rgb_conv_chk.sv
`timescale 1ns/1ps
module ycc_rgb_conv_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_r,
  input logic [DW-1:0] m_g,
  input logic [DW-1:0] m_b,
  input logic          cfg_commit,
  input logic [DW-1:0] act_max,
  input logic [DW-1:0] act_min
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (!en || (m_valid && $stable(m_r) && $stable(m_g) && $stable(m_b))));

  // R7
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!m_valid && s_ready));

  // R9
  commit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg_commit) |=> (!en || !s_ready));

  // R5
  limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && act_min <= act_max) |->
      (m_r <= act_max && m_r >= act_min && m_g <= act_max && m_g >= act_min &&
       m_b <= act_max && m_b >= act_min));

  // R5
  limit_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && act_min > act_max) |-> (m_r == act_min && m_g == act_min && m_b == act_min));
endmodule

bind ycc_rgb_conv ycc_rgb_conv_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_r(m_r), .m_g(m_g), .m_b(m_b), .cfg_commit(cfg_commit),
  .act_max(act_max), .act_min(act_min)
);

// File: tb/ycc_rgb_conv_tb.sv
`timescale 1ns/1ps
module ycc_rgb_conv_tb;
  localparam int DW = 8, CW = 17, OFW = 32, CFRAC = 14;
  localparam longint UNITY = 64'd1 << CFRAC;

  logic clk = 0, rst_n = 0, en = 0, s_valid = 0, m_ready = 0, cfg_commit = 0;
  logic [DW-1:0] s_y = 0, s_cb = 0, s_cr = 0;
  logic s_ready, m_valid;
  logic [DW-1:0] m_r, m_g, m_b;
  logic signed [CW-1:0]  cfg_a = 0, cfg_b = 0, cfg_c = 0, cfg_d = 0;
  logic signed [OFW-1:0] cfg_or = 0, cfg_og = 0, cfg_ob = 0;
  logic [DW-1:0] cfg_hi = 0, cfg_lo = 0;

  int ka = 0, kb = 0, kc = 0, kd = 0, mo_r = 0, mo_g = 0, mo_b = 0, mhi = 255, mlo = 0;
  int na, nb, nc, nd, no_r, no_g, no_b, nhi, nlo;
  bit pend_m = 0;
  logic [3*DW-1:0] exp_q[$];
  int nchk = 0, nfail = 0;
  string cur_req = "R1";
  bit obs_mv, obs_sr, done = 0;
  logic [DW-1:0] obs_r, obs_g, obs_b;

  always #2.5 clk = ~clk;

  ycc_rgb_conv u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .s_valid(s_valid), .s_ready(s_ready),
    .s_y(s_y), .s_cb(s_cb), .s_cr(s_cr), .m_valid(m_valid), .m_ready(m_ready),
    .m_r(m_r), .m_g(m_g), .m_b(m_b), .cfg_commit(cfg_commit),
    .cfg_coef_a(cfg_a), .cfg_coef_b(cfg_b), .cfg_coef_c(cfg_c), .cfg_coef_d(cfg_d),
    .cfg_off_r(cfg_or), .cfg_off_g(cfg_og), .cfg_off_b(cfg_ob),
    .cfg_max(cfg_hi), .cfg_min(cfg_lo)
  );

  // floor((Y*unity + kcr*Cr + kcb*Cb + off) / unity), clip to hi, then clamp to lo
  function automatic int ref_ch(int yv, int crv, int cbv, int kcr, int kcb, int offv,
                                int hv, int lv);
    longint s, q;
    int r;
    s = longint'(yv) * UNITY + longint'(kcr) * crv + longint'(kcb) * cbv + longint'(offv);
    q = s >>> CFRAC;
    if (q > hv) r = hv; else r = int'(q);
    if (r < lv) r = lv;
    return r;
  endfunction

  task automatic chk(string req, int act, int expv, string what);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    logic [3*DW-1:0] e;
    int r, g, b;
    #1;
    obs_mv = m_valid; obs_sr = s_ready; obs_r = m_r; obs_g = m_g; obs_b = m_b;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) chk(cur_req, 1, 0, "unexpected output pixel");
      else begin
        e = exp_q.pop_front();
        chk(cur_req, int'(m_r), int'(e[3*DW-1 -: DW]), "red");
        chk(cur_req, int'(m_g), int'(e[2*DW-1 -: DW]), "green");
        chk(cur_req, int'(m_b), int'(e[DW-1:0]), "blue");
      end
    end
    if (en && s_valid && s_ready) begin
      if (pend_m) begin
        ka = na; kb = nb; kc = nc; kd = nd; mo_r = no_r; mo_g = no_g; mo_b = no_b;
        mhi = nhi; mlo = nlo; pend_m = 0;
      end
      r = ref_ch(s_y, s_cr, s_cb, ka, 0, mo_r, mhi, mlo);
      g = ref_ch(s_y, s_cr, s_cb, kb, kc, mo_g, mhi, mlo);
      b = ref_ch(s_y, s_cr, s_cb, 0, kd, mo_b, mhi, mlo);
      exp_q.push_back({DW'(r), DW'(g), DW'(b)});
    end
    if (cfg_commit) begin
      pend_m = 1;
      na = int'(cfg_a); nb = int'(cfg_b); nc = int'(cfg_c); nd = int'(cfg_d);
      no_r = int'(cfg_or); no_g = int'(cfg_og); no_b = int'(cfg_ob);
      nhi = int'(cfg_hi); nlo = int'(cfg_lo);
    end
    @(negedge clk);
  endtask

  task automatic commit_cfg(int a, int b, int c, int d, int o1, int o2, int o3, int h, int l);
    cfg_a = CW'(a); cfg_b = CW'(b); cfg_c = CW'(c); cfg_d = CW'(d);
    cfg_or = o1; cfg_og = o2; cfg_ob = o3; cfg_hi = DW'(h); cfg_lo = DW'(l);
    cfg_commit = 1;
    step();
    cfg_commit = 0;
  endtask

  task automatic rnd_px();
    s_y = DW'($urandom); s_cb = DW'($urandom); s_cr = DW'($urandom);
  endtask

  task automatic idle(int n);
    s_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) begin
      s_valid = 1; rnd_px(); step();
    end
    idle(5);
  endtask

  initial begin
    logic [DW-1:0] held;
    bit seen;
    void'($urandom(32'h1234_5EED));
    @(negedge clk);
    // R1 reset state
    en = 1;
    step(); step();
    chk("R1", obs_mv, 0, "m_valid in reset");
    chk("R1", obs_sr, 1, "s_ready in reset");
    rst_n = 1;
    step();
    chk("R1", obs_mv, 0, "m_valid after reset");
    m_ready = 1;
    // R1 pass-through with default active set
    cur_req = "R1";
    s_valid = 1; s_y = 0;   s_cb = 200; s_cr = 17;  step();
    s_y = 128; s_cb = 0;   s_cr = 255; step();
    s_y = 255; s_cb = 255; s_cr = 0;   step();
    idle(5);

    // R6 latency
    cur_req = "R6";
    s_valid = 1; rnd_px(); step();
    s_valid = 0;
    step(); chk("R6", obs_mv, 0, "valid one edge after accept");
    step(); chk("R6", obs_mv, 0, "valid two edges after accept");
    step(); chk("R6", obs_mv, 1, "valid three edges after accept");
    idle(3);

    // R2 red path only
    cur_req = "R2";
    commit_cfg(26149, 0, 0, 0, -26149 * 128 - 16 * 16384 + 8192, 0, 0, 255, 0);
    burst(40);

    // R3 green and blue paths
    cur_req = "R3";
    commit_cfg(0, -13320, -6420, 33050, 0, 13320 * 128 + 6420 * 128 + 8192,
               -33050 * 128 + 8192, 255, 0);
    burst(60);

    // R4 offset folding and truncation
    cur_req = "R4";
    commit_cfg(0, 0, 0, 0, -1, 8191, -16385, 255, 0);
    s_cb = 9; s_cr = 77;
    s_valid = 1;
    s_y = 0; step(); s_y = 1; step(); s_y = 2; step(); s_y = 100; step(); s_y = 255; step();
    idle(5);

    // R5 clip, clamp and crossed limits
    cur_req = "R5";
    commit_cfg(40000, 30000, 30000, -40000, 0, 0, 0, 240, 16);
    s_valid = 1;
    s_y = 255; s_cr = 255; s_cb = 255; step();
    s_y = 0;   s_cr = 0;   s_cb = 255; step();
    s_y = 128; s_cr = 0;   s_cb = 0;   step();
    burst(20);
    commit_cfg(0, 0, 0, 0, 0, 0, 0, 10, 200);
    burst(10);

    // R7 stall holds output, R9 commit queued behind the stall
    cur_req = "R7";
    commit_cfg(20000, -9000, -5000, 25000, -20000 * 128, 14000 * 128, -25000 * 128, 255, 0);
    idle(3);
    m_ready = 0;
    for (int i = 0; i < 5; i++) begin s_valid = 1; rnd_px(); step(); end
    held = obs_r;
    step();
    chk("R7", obs_sr, 0, "s_ready while stalled");
    chk("R7", obs_mv, 1, "m_valid while stalled");
    chk("R7", int'(obs_r), int'(held), "red held while stalled");
    cur_req = "R9";
    commit_cfg(-15000, 7000, 7000, 15000, 15000 * 128, -14000 * 128, -15000 * 128, 235, 16);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9", obs_sr, 0, "s_ready low during pending commit");
    end
    m_ready = 1;
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      step();
      if (obs_sr) seen = 1;
    end
    chk("R9", seen, 1, "s_ready returns after drain");
    burst(20);

    // R8 disable drops in-flight pixels and ignores input
    cur_req = "R8";
    s_valid = 1; rnd_px(); step(); rnd_px(); step();
    en = 0;
    exp_q.delete();
    for (int i = 0; i < 5; i++) begin
      rnd_px(); step();
      chk("R8", obs_mv, 0, "m_valid while disabled");
      chk("R8", obs_sr, 1, "s_ready while disabled");
    end
    en = 1;
    s_valid = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R8", obs_mv, 0, "no stale output after enable");
    end

    // R10 inputs changed without commit have no effect
    cur_req = "R10";
    cfg_a = 17'sd999; cfg_d = -17'sd999; cfg_or = 32'sd123456; cfg_hi = 8'd50; cfg_lo = 8'd40;
    burst(30);

    // R7 random traffic with occasional commits
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      if (i % 800 == 400) begin
        s_valid = 0;
        commit_cfg(int'($urandom_range(0, 131071)) - 65536, int'($urandom_range(0, 131071)) - 65536,
                   int'($urandom_range(0, 131071)) - 65536, int'($urandom_range(0, 131071)) - 65536,
                   int'($urandom_range(0, 8388607)) - 4194304, int'($urandom_range(0, 8388607)) - 4194304,
                   int'($urandom_range(0, 8388607)) - 4194304,
                   int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      end
      s_valid = ($urandom_range(0, 9) < 7);
      m_ready = ($urandom_range(0, 9) < 7);
      rnd_px();
      step();
    end
    m_ready = 1;
    idle(8);
    chk("R7", exp_q.size(), 0, "pixels left undelivered");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule